// File: doc/BRIEF.md
# Chained DMA Bus Arbiter

This block shares one internal DMA bus among several link channels. The bus moves at most one word per cycle between on-chip memory and the channels. Each channel moves blocks of a fixed number of words. It asks for the bus one word at a time. The memory side and the link serialisers sit outside the block: a channel's word request stands in for "a word is ready to move", and a grant stands in for "the word moves in this cycle".

When a channel finishes a block with chaining enabled, it must fetch its next descriptor before it can continue. That fetch takes a fixed number of consecutive bus cycles, and no data moves on the bus during it. The fetch request competes in the same round-robin as the data requests. Only one fetch runs at a time, and later fetch requests wait their turn in round-robin order. A channel that finishes a block with chaining disabled stops and stays idle until a new start strobe arms it.

Each channel runs a four-state machine:

| State | Meaning |
|---|---|
| CH_IDLE | The channel is not armed. |
| CH_XFER | The channel is moving words. |
| CH_WAIT | The channel wants a descriptor fetch. |
| CH_FETCH | The channel owns the bus for the fetch. |

The channel moves between these states as follows:

| From | To | Condition |
|---|---|---|
| CH_IDLE | CH_XFER | Start strobe. |
| CH_XFER | CH_WAIT | Final word granted with chaining on. |
| CH_XFER | CH_IDLE | Final word granted with chaining off. |
| CH_WAIT | CH_FETCH | The channel wins arbitration. |
| CH_FETCH | CH_XFER | Last fetch cycle. |

A shared fetch controller has two states:

| State | Meaning |
|---|---|
| FC_FREE | No fetch is running. |
| FC_BUSY | A fetch is running. |

It goes from FC_FREE to FC_BUSY when a fetch wins arbitration. It goes from FC_BUSY back to FC_FREE on the last fetch cycle.

Top module: `chain_dma_arbiter`

## Requirements
- R1: After reset every channel is idle. grant_o, fetch_o and done_o are all zero, and word requests get no grant until a channel is started.
- R2: A start strobe on an idle channel arms it with BLOCK_LEN words. A start strobe on a channel that is not idle has no effect on its remaining word count.
- R3: In any cycle at most one bit of the concatenation {grant_o, fetch_o} is high. Bit i of every per-channel vector belongs to channel i.
- R4: A data grant goes only to an armed channel whose word request is high. Candidates are searched round-robin, starting one place after the last winner. Right after reset, channel 0 is searched first.
- R5: Each grant lowers the channel's word count by one. done_o[i] is high for exactly one cycle: the cycle after the grant of the channel's BLOCK_LEN-th word.
- R6: If chain_en_i[i] is low when the final word is granted, the channel goes idle. It gets no grants until it sees a new start strobe.
- R7: If chain_en_i[i] is high when the final word is granted, the channel requests a descriptor fetch. This request takes part in the same round-robin as data requests. Once the fetch wins, fetch_o[i] is high for exactly RELOAD_CYC consecutive cycles, starting in the winning cycle. The channel then continues with a fresh block of BLOCK_LEN words.
- R8: While a fetch is running, no channel gets a data grant and no second fetch can start. Waiting fetches are served in round-robin order once the bus is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | NUM_CH | Per-channel start strobe that arms an idle channel |
| chain_en_i | input | NUM_CH | Per-channel chaining enable, sampled at the final word of a block |
| word_req_i | input | NUM_CH | Per-channel request for one word transfer |
| grant_o | output | NUM_CH | One-hot data grant; the word moves in this cycle |
| fetch_o | output | NUM_CH | High while that channel's descriptor fetch holds the bus |
| done_o | output | NUM_CH | One-cycle pulse after the final word of a block |

## Verification
A descriptor fetch request and another channel's data request can fall in the same cycle. The bench provokes this by running two chained channels that both request on every cycle, so that one finishes its block while the other still has a word to move. In one such cycle the data request must win because it is next in the rotation. In a later cycle the waiting fetch must win over a data request and hold off every grant for its full length. Both outcomes are judged against the round-robin order worked out from the sequence of past winners.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_XFER  = 2'd1,
        CH_WAIT  = 2'd2,
        CH_FETCH = 2'd3
    } ch_state_e;

    typedef enum logic {
        FC_FREE = 1'b0,
        FC_BUSY = 1'b1
    } fc_state_e;

endpackage

// File: rtl/dmarb_rr_pick.sv
module dmarb_rr_pick #(
    parameter int NUM_CH = 6,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req_i,
    input  logic [IDX_W-1:0]  last_i,
    output logic [NUM_CH-1:0] win_o,
    output logic [IDX_W-1:0]  win_idx_o,
    output logic              any_o
);

    // Search starts one place after the previous winner and wraps.
    always_comb begin
        win_o     = '0;
        win_idx_o = '0;
        any_o     = 1'b0;
        for (int k = 1; k <= NUM_CH; k++) begin
            int t;
            t = int'(last_i) + k;
            if (t >= NUM_CH) begin
                t = t - NUM_CH;
            end
            if (!any_o && req_i[IDX_W'(t)]) begin
                win_o[IDX_W'(t)] = 1'b1;
                win_idx_o        = IDX_W'(t);
                any_o            = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dmarb_fetch_ctl.sv
module dmarb_fetch_ctl
    import dmarb_pkg::*;
#(
    parameter int RELOAD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic begin_i,
    output logic busy_o,
    output logic last_o
);

    localparam int RC_W = $clog2(RELOAD_CYC + 1);
    localparam logic [RC_W-1:0] LAST_CNT = RC_W'(RELOAD_CYC - 1);

    fc_state_e       state_q, state_d;
    logic [RC_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FC_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // cycle counter; the winning cycle is fetch cycle 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (begin_i) begin
            cnt_q <= RC_W'(1);
        end else if (state_q == FC_BUSY) begin
            cnt_q <= (cnt_q == LAST_CNT) ? '0 : cnt_q + RC_W'(1);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_FREE: if (begin_i) state_d = FC_BUSY;
            FC_BUSY: if (cnt_q == LAST_CNT) state_d = FC_FREE;
            default: state_d = FC_FREE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o = (state_q == FC_BUSY);
        last_o = (state_q == FC_BUSY) && (cnt_q == LAST_CNT);
    end

    AST_FETCH_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !begin_i) else $error("fetch began while bus locked"); // R8

endmodule

// File: rtl/dmarb_channel.sv
module dmarb_channel
    import dmarb_pkg::*;
#(
    parameter int BLOCK_LEN = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic chain_en_i,
    input  logic word_req_i,
    input  logic win_i,
    input  logic fetch_last_i,
    output logic req_o,
    output logic waiting_o,
    output logic grant_o,
    output logic fetch_o,
    output logic done_o
);

    localparam int CNT_W = $clog2(BLOCK_LEN + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BLOCK_LEN);

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             last_word;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        req_o     = 1'b0;
        waiting_o = 1'b0;
        grant_o   = 1'b0;
        fetch_o   = 1'b0;
        unique case (state_q)
            CH_IDLE:  ;
            CH_XFER:  begin
                req_o   = word_req_i;
                grant_o = win_i;
            end
            CH_WAIT:  begin
                req_o     = 1'b1;
                waiting_o = 1'b1;
                fetch_o   = win_i;
            end
            CH_FETCH: fetch_o = 1'b1;
            default:  ;
        endcase
    end

    assign last_word = grant_o && (cnt_q == CNT_W'(1));
    assign done_o    = done_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:  if (start_i) state_d = CH_XFER;
            CH_XFER:  if (last_word) state_d = chain_en_i ? CH_WAIT : CH_IDLE;
            CH_WAIT:  if (win_i) state_d = CH_FETCH;
            CH_FETCH: if (fetch_last_i) state_d = CH_XFER;
            default:  state_d = CH_IDLE;
        endcase
    end

    // word counter and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= last_word;
            if (state_q == CH_IDLE && start_i) begin
                cnt_q <= FULL;
            end else if (state_q == CH_FETCH && fetch_last_i) begin
                cnt_q <= FULL;
            end else if (grant_o) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> word_req_i) else $error("grant without request"); // R4

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CH_IDLE && start_i && !grant_o &&
         !(state_q == CH_FETCH && fetch_last_i)) |=> $stable(cnt_q))
        else $error("start altered a busy channel"); // R2

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q) else $error("done longer than one cycle"); // R5

    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_IDLE && !start_i) |=> !grant_o)
        else $error("grant to unarmed channel"); // R6

endmodule

// File: rtl/chain_dma_arbiter.sv
module chain_dma_arbiter
    import dmarb_pkg::*;
#(
    parameter int NUM_CH     = 6,
    parameter int BLOCK_LEN  = 1024,
    parameter int RELOAD_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] start_i,
    input  logic [NUM_CH-1:0] chain_en_i,
    input  logic [NUM_CH-1:0] word_req_i,
    output logic [NUM_CH-1:0] grant_o,
    output logic [NUM_CH-1:0] fetch_o,
    output logic [NUM_CH-1:0] done_o
);

    localparam int IDX_W = $clog2(NUM_CH);
    localparam int RUN_W = $clog2(RELOAD_CYC + 1) + 1;

    logic [NUM_CH-1:0] req_vec, wait_vec, win_vec, masked;
    logic [IDX_W-1:0]  ptr_q, win_idx;
    logic              any_win, busy, fetch_last, fetch_begin;

    // a running fetch locks out every contender
    assign masked      = busy ? '0 : req_vec;
    assign fetch_begin = |(win_vec & wait_vec);

    dmarb_rr_pick #(.NUM_CH(NUM_CH)) u_pick (
        .req_i     (masked),
        .last_i    (ptr_q),
        .win_o     (win_vec),
        .win_idx_o (win_idx),
        .any_o     (any_win)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= IDX_W'(NUM_CH - 1);
        end else if (any_win) begin
            ptr_q <= win_idx;
        end
    end

    dmarb_fetch_ctl #(.RELOAD_CYC(RELOAD_CYC)) u_fetch (
        .clk     (clk),
        .rst_n   (rst_n),
        .begin_i (fetch_begin),
        .busy_o  (busy),
        .last_o  (fetch_last)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dmarb_channel #(.BLOCK_LEN(BLOCK_LEN)) u_ch (
            .clk          (clk),
            .rst_n        (rst_n),
            .start_i      (start_i[g]),
            .chain_en_i   (chain_en_i[g]),
            .word_req_i   (word_req_i[g]),
            .win_i        (win_vec[g]),
            .fetch_last_i (fetch_last),
            .req_o        (req_vec[g]),
            .waiting_o    (wait_vec[g]),
            .grant_o      (grant_o[g]),
            .fetch_o      (fetch_o[g]),
            .done_o       (done_o[g])
        );
    end

    // length of the fetch run most recently started
    logic [RUN_W-1:0] fetch_run;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_run <= '0;
        end else if (fetch_begin) begin
            fetch_run <= RUN_W'(1);
        end else if (|fetch_o && fetch_run != '1) begin
            fetch_run <= fetch_run + RUN_W'(1);
        end
    end

    AST_BUS_ONE_USE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_o, fetch_o})) else $error("bus used twice"); // R3

    AST_NO_GRANT_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (grant_o == '0)) else $error("grant during fetch"); // R8

    AST_FETCH_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_begin |-> (fetch_run == '0 || fetch_run == RUN_W'(RELOAD_CYC)))
        else $error("fetch run of wrong length"); // R7

    AST_FETCH_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
        (|fetch_o && !fetch_begin) |-> (fetch_run < RUN_W'(RELOAD_CYC)))
        else $error("fetch overran"); // R7

endmodule

// File: tb/sim_chain_dma_arbiter.sv
module sim_chain_dma_arbiter;

    localparam int N  = 6;
    localparam int BL = 4;
    localparam int RC = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] start = '0, chain = '0, req = '0;
    logic [N-1:0] grant, fetch, done;
    int           n_run = 0;
    int           n_fail = 0;
    bit           finished = 1'b0;

    always #2 clk = ~clk;

    chain_dma_arbiter #(.NUM_CH(N), .BLOCK_LEN(BL), .RELOAD_CYC(RC)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .chain_en_i (chain),
        .word_req_i (req),
        .grant_o    (grant),
        .fetch_o    (fetch),
        .done_o     (done)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // drive at the falling edge, then compare the outputs of this cycle
    task automatic step(input logic [N-1:0] st, input logic [N-1:0] rq,
                        input logic [N-1:0] eg, input logic [N-1:0] ef,
                        input logic [N-1:0] ed, input string tag);
        @(negedge clk);
        start = st;
        req   = rq;
        #1;
        chk({tag, " grant"}, grant, eg);
        chk({tag, " fetch"}, fetch, ef);
        chk({tag, " done"}, done, ed);
        n_run++;
        if (!$onehot0({grant, fetch})) begin
            n_fail++;
            $display("FAIL R3 one bus use: actual %b expected at most one bit", {grant, fetch});
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        start = '0;
        req   = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chain = '1;
        for (int i = 0; i < 3; i++) step('0, '1, '0, '0, '0, "R1 idle after reset");
    endtask

    task automatic t_single_stop();
        do_reset();
        chain = '0;
        step(6'b000001, '0, '0, '0, '0, "R2 arm");
        step('0, 6'b000001, 6'b000001, '0, '0, "R5 word1");
        step(6'b000001, 6'b000001, 6'b000001, '0, '0, "R2 start while busy");
        step('0, '0, '0, '0, '0, "R5 request gap");
        step('0, 6'b000001, 6'b000001, '0, '0, "R5 word3");
        step('0, 6'b000001, 6'b000001, '0, '0, "R5 word4");
        step('0, 6'b000001, '0, '0, 6'b000001, "R5 done pulse");
        step('0, 6'b000001, '0, '0, '0, "R6 stays idle");
        step(6'b000001, 6'b000001, '0, '0, '0, "R2 re-arm");
        step('0, 6'b000001, 6'b000001, '0, '0, "R2 after re-arm");
    endtask

    task automatic t_round_robin();
        do_reset();
        chain = '0;
        step(6'b000111, '0, '0, '0, '0, "R4 arm three");
        step('0, 6'b000111, 6'b000001, '0, '0, "R4 first ch0");
        step('0, 6'b000111, 6'b000010, '0, '0, "R4 then ch1");
        step('0, 6'b000111, 6'b000100, '0, '0, "R4 then ch2");
        step('0, 6'b000101, 6'b000001, '0, '0, "R4 wrap skips");
        step('0, 6'b000111, 6'b000010, '0, '0, "R4 ch1");
        step('0, 6'b000111, 6'b000100, '0, '0, "R4 ch2");
        step('0, 6'b000111, 6'b000001, '0, '0, "R4 ch0");
        step('0, 6'b000111, 6'b000010, '0, '0, "R4 ch1");
        step('0, 6'b000111, 6'b000100, '0, '0, "R4 ch2");
        step('0, 6'b000111, 6'b000001, '0, '0, "R4 ch0 last");
        step('0, 6'b000111, 6'b000010, '0, 6'b000001, "R5 ch0 done");
        step('0, 6'b000111, 6'b000100, '0, 6'b000010, "R5 ch1 done");
        step('0, 6'b000111, '0, '0, 6'b000100, "R6 all idle");
    endtask

    task automatic t_chain_single();
        do_reset();
        chain = 6'b000001;
        step(6'b000001, '0, '0, '0, '0, "R7 arm");
        for (int i = 0; i < BL; i++) step('0, 6'b000001, 6'b000001, '0, '0, "R7 block words");
        step('0, 6'b000001, '0, 6'b000001, 6'b000001, "R7 fetch starts with done");
        for (int i = 1; i < RC; i++) step('0, 6'b000001, '0, 6'b000001, '0, "R7 fetch holds");
        step('0, 6'b000001, 6'b000001, '0, '0, "R7 new block");
    endtask

    task automatic t_fetch_queue();
        do_reset();
        chain = 6'b000011;
        step(6'b000011, '0, '0, '0, '0, "R8 arm two");
        for (int i = 0; i < 3; i++) begin
            step('0, 6'b000011, 6'b000001, '0, '0, "R4 ch0 word");
            step('0, 6'b000011, 6'b000010, '0, '0, "R4 ch1 word");
        end
        step('0, 6'b000011, 6'b000001, '0, '0, "R4 ch0 last");
        step('0, 6'b000011, 6'b000010, '0, 6'b000001, "R8 data beats fetch");
        step('0, 6'b000011, '0, 6'b000001, 6'b000010, "R8 ch0 fetch first");
        for (int i = 1; i < RC; i++) step('0, 6'b000011, '0, 6'b000001, '0, "R8 no second fetch");
        step('0, 6'b000011, '0, 6'b000010, '0, "R8 fetch beats data");
        for (int i = 1; i < RC; i++) step('0, 6'b000011, '0, 6'b000010, '0, "R8 no grant during fetch");
        step('0, 6'b000011, 6'b000001, '0, '0, "R7 ch0 resumes");
        step('0, 6'b000011, 6'b000010, '0, '0, "R7 ch1 resumes");
    endtask

    initial begin
        t_reset();
        t_single_stop();
        t_round_robin();
        t_chain_single();
        t_fetch_queue();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule